// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides when an external master may take over the external bus. It watches an active-low hold request and the CPU's bus-busy indication. A request is honoured only on a high-to-low transition of the internal clock phase, and only while no CPU bus cycle is running. When the request is honoured, the active-low hold acknowledge output goes low. A fixed number of phase periods later, a global output enable drops so that the address, data and strobe pins float.

Release runs the same steps in reverse order. The acknowledge returns high first. The pins resume driving a fixed number of phase periods after that. For as long as the block is anywhere outside its idle state, it raises a stall output so that the CPU launches no new external bus cycle.

The clock phase, the bus-busy indication and the hold request are all sampled on the system clock. Each phase period counts as one step of the lag timer.

Top module: `bus_hold_arbiter`

## Requirements
- R1: During and after reset, hold_ack_n is 1, pin_oe is 1 and cpu_stall is 0.
- R2: A low hold_req_n is granted only in a clock cycle where phase was 1 in the previous cycle and is 0 now. A steady or rising phase never grants.
- R3: No grant is made at a phase fall while bus_busy is 1. A request still low when busy clears is granted at the first phase fall after that.
- R4: hold_ack_n goes to 0 on the clock edge that carries the qualifying phase fall, while pin_oe stays 1.
- R5: pin_oe goes to 0 at the LAG_PHI-th phase fall after hold_ack_n fell (default 1).
- R6: While the pins float, the first phase fall with hold_req_n at 1 returns hold_ack_n to 1, and pin_oe stays 0.
- R7: pin_oe returns to 1 at the LAG_PHI-th phase fall after hold_ack_n rose. A request present during this time is not granted before the pins drive again.
- R8: cpu_stall is 1 whenever hold_ack_n is 0 or pin_oe is 0.
- R9: Once a grant has been made, bus_busy has no effect on the outputs.
- R10: A request withdrawn before the pins float still completes the float step, and the release follows at the next phase fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 1 | Internal clock phase level |
| bus_busy | input | 1 | CPU bus cycle in progress |
| hold_req_n | input | 1 | Active-low hold request from the external master |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| pin_oe | output | 1 | Global enable for the address, data and strobe pin drivers |
| cpu_stall | output | 1 | Stops the CPU from starting a new external bus cycle |

## Verification
The hardest case to reach is a request that lands while a bus cycle is running. The request must not be granted at a phase fall where busy is still high. After busy clears, no grant may occur until the next fall. The stimulus holds the request low across a phase fall with busy high. It then drops busy while phase is high, so the pending request has to wait for the next fall before it is granted. A second case withdraws the request during the grant-to-float lag. The pins must still float, and the release must follow one fall later.

// File: rtl/bh_pkg.sv
package bh_pkg;

  typedef enum logic [1:0] {
    BH_IDLE   = 2'd0,
    BH_GRANT  = 2'd1,
    BH_FLOAT  = 2'd2,
    BH_RESUME = 2'd3
  } bh_state_e;

  // acknowledge is low while the grant is held and the pins float
  function automatic logic ack_low(input bh_state_e s);
    return (s == BH_GRANT) || (s == BH_FLOAT);
  endfunction

  // pins are driven while idle and during the grant lag
  function automatic logic pins_drive(input bh_state_e s);
    return (s == BH_IDLE) || (s == BH_GRANT);
  endfunction

  function automatic logic stall_cpu(input bh_state_e s);
    return s != BH_IDLE;
  endfunction

  function automatic int lag_width(input int lag);
    return (lag < 1) ? 1 : $clog2(lag + 1);
  endfunction

endpackage

// File: rtl/bh_phase_edge.sv
module bh_phase_edge #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  output logic phase_fall
);
  logic phase_s;
  logic phase_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign phase_s = phase;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], phase};
      end
      assign phase_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= phase_s;
  end

  assign phase_fall = phase_q & ~phase_s;
endmodule

// File: rtl/bh_lag_timer.sv
module bh_lag_timer #(
  parameter int LAG_PHI = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tick,
  output logic expire
);
  localparam int CW = bh_pkg::lag_width(LAG_PHI);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LAG_PHI);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= LOAD_VAL;
    else if (tick && cnt != '0) cnt <= cnt - ONE;
  end

  assign expire = tick && (cnt == ONE);
endmodule

// File: rtl/bh_sequencer.sv
module bh_sequencer
  import bh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      phase_fall,
  input  logic      bus_busy,
  input  logic      hold_req_n,
  input  logic      lag_expire,
  output bh_state_e state,
  output logic      grant_evt,
  output logic      release_evt,
  output logic      lag_load
);
  bh_state_e state_nx;

  assign grant_evt   = (state == BH_IDLE) && phase_fall && !bus_busy && !hold_req_n;
  assign release_evt = (state == BH_FLOAT) && phase_fall && hold_req_n;
  assign lag_load    = grant_evt | release_evt;

  always_comb begin
    state_nx = state;
    unique case (state)
      BH_IDLE:   if (grant_evt)   state_nx = BH_GRANT;
      BH_GRANT:  if (lag_expire)  state_nx = BH_FLOAT;
      BH_FLOAT:  if (release_evt) state_nx = BH_RESUME;
      BH_RESUME: if (lag_expire)  state_nx = BH_IDLE;
      default:                    state_nx = BH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BH_IDLE;
    else        state <= state_nx;
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bh_pkg::*;
#(
  parameter int LAG_PHI     = 1,
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic phase,
  input  logic bus_busy,
  input  logic hold_req_n,
  output logic hold_ack_n,
  output logic pin_oe,
  output logic cpu_stall
);
  logic      phase_fall;
  logic      lag_expire;
  logic      lag_load;
  logic      grant_evt;
  logic      release_evt;
  bh_state_e state;

  bh_phase_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_fall(phase_fall)
  );

  bh_lag_timer #(.LAG_PHI(LAG_PHI)) u_lag (
    .clk(clk), .rst_n(rst_n), .load(lag_load), .tick(phase_fall), .expire(lag_expire)
  );

  bh_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .phase_fall(phase_fall), .bus_busy(bus_busy),
    .hold_req_n(hold_req_n), .lag_expire(lag_expire), .state(state),
    .grant_evt(grant_evt), .release_evt(release_evt), .lag_load(lag_load)
  );

  assign hold_ack_n = ~ack_low(state);
  assign pin_oe     = pins_drive(state);
  assign cpu_stall  = stall_cpu(state);
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_busy,
  input logic hold_req_n,
  input logic phase_fall,
  input logic hold_ack_n,
  input logic pin_oe,
  input logic cpu_stall
);
  assert_grant_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> ($past(phase_fall) && !$past(bus_busy) && !$past(hold_req_n)));

  assert_ack_before_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack_n) |-> pin_oe);

  assert_float_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pin_oe) |-> ($past(phase_fall) && !hold_ack_n));

  assert_release_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack_n) |-> ($past(phase_fall) && $past(hold_req_n) && !pin_oe));

  assert_drive_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_oe) |-> ($past(phase_fall) && hold_ack_n));

  assert_stall_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack_n || !pin_oe) |-> cpu_stall);
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .hold_req_n(hold_req_n),
  .phase_fall(phase_fall), .hold_ack_n(hold_ack_n), .pin_oe(pin_oe),
  .cpu_stall(cpu_stall)
);

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase = 1'b0;
  logic bus_busy = 1'b0;
  logic hold_req_n = 1'b1;
  logic hold_ack_n, pin_oe, cpu_stall;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  ack;
    logic  oe;
    logic  st;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  bus_hold_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .phase(phase), .bus_busy(bus_busy),
    .hold_req_n(hold_req_n), .hold_ack_n(hold_ack_n), .pin_oe(pin_oe),
    .cpu_stall(cpu_stall)
  );

  // state shorthands for expected outputs: I idle, G granted, F floating, S resuming
  localparam logic [2:0] I = 3'b110, G = 3'b011, F = 3'b001, S = 3'b101;

  task automatic step(input logic ph, input logic b, input logic rq,
                      input logic [2:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    phase = ph; bus_busy = b; hold_req_n = rq;
    x.ack = e[2]; x.oe = e[1]; x.st = e[0]; x.tag = tag;
    sb.push_back(x);
  endtask

  // monitor: pops one expectation per clock, sampled after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() != 0) begin
        exp_t x;
        x = sb.pop_front();
        n_vec++;
        if (hold_ack_n !== x.ack || pin_oe !== x.oe || cpu_stall !== x.st) begin
          n_bad++;
          $display("FAIL %s: ack/oe/stall got %b%b%b expected %b%b%b",
                   x.tag, hold_ack_n, pin_oe, cpu_stall, x.ack, x.oe, x.st);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    n_vec++;
    if (hold_ack_n !== 1'b1 || pin_oe !== 1'b1 || cpu_stall !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset got %b%b%b expected 110", hold_ack_n, pin_oe, cpu_stall);
    end
    rst_n = 1'b1;
    step(0, 0, 1, I, "R1");
    // R2: request low, phase rising or steady: no grant
    step(1, 0, 0, I, "R2");
    step(1, 0, 0, I, "R2");
    step(1, 0, 0, I, "R2");
    // R4: qualifying fall grants, pins still driven; R8 stall
    step(0, 0, 0, G, "R4");
    step(0, 0, 0, G, "R8");
    step(1, 0, 0, G, "R5");
    // R5: next fall floats the pins
    step(0, 0, 0, F, "R5");
    step(0, 0, 1, F, "R6");
    step(1, 0, 1, F, "R6");
    // R6: fall with request high releases acknowledge, pins still float
    step(0, 0, 1, S, "R6");
    step(1, 0, 1, S, "R7");
    // R7: next fall drives the pins again
    step(0, 0, 1, I, "R7");
    // R3: request during bus cycle is held off
    step(1, 1, 0, I, "R3");
    step(0, 1, 0, I, "R3");
    step(1, 1, 0, I, "R3");
    step(1, 0, 0, I, "R3");
    step(0, 0, 0, G, "R3");
    // R9: busy ignored after grant
    step(1, 1, 0, G, "R9");
    step(0, 1, 0, F, "R9");
    step(1, 1, 0, F, "R9");
    step(0, 1, 0, F, "R9");
    step(1, 0, 1, F, "R6");
    step(0, 0, 1, S, "R6");
    // R7: new request during resume is not granted before pins drive
    step(1, 0, 0, S, "R7");
    step(0, 0, 0, I, "R7");
    step(1, 0, 0, I, "R7");
    step(0, 0, 0, G, "R2");
    // R10: request withdrawn during grant lag
    step(1, 0, 1, G, "R10");
    step(0, 0, 1, F, "R10");
    step(1, 0, 1, F, "R10");
    step(0, 0, 1, S, "R10");
    step(1, 0, 1, S, "R10");
    step(0, 0, 1, I, "R10");
    step(1, 0, 1, I, "R2");
    step(0, 0, 1, I, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule